// File: doc/BRIEF.md
# Serial EEPROM Page Write Engine

This block is the write-path core of a byte-addressed serial EEPROM slave. A bit-level front end, which is not part of this block, turns the two-wire bus into single-cycle event pulses: a start condition, a stop condition, and a received byte. The engine sorts these events into the device-select byte, the word-address byte and the data bytes. It returns an acknowledge decision for every byte and gathers up to one page of data in a small buffer.

A stop that follows at least one data byte opens an internally timed write cycle of fixed length. During that cycle the buffered bytes reach the memory array through a simple synchronous write port. The address counter advances only within the current page, so a long burst wraps to the start of the page and overwrites the bytes sent earlier. While the cycle runs, the engine ignores bus events and refuses to acknowledge anything. A master can therefore poll with repeated start and device-select bytes until it gets an acknowledge. A protection decision made elsewhere arrives on one input. A blocked write still runs the full timed cycle but leaves the array untouched.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy, mem_we and ack_vld are all low.
- R2: A device-select byte received right after a start is acknowledged when bits 7:4 equal 4'b1010 and bits 3:1 equal chip_sel. The acknowledge appears as ack_vld high with ack_n low on the cycle after the byte pulse. Bit 0 is the direction: 0 means write, 1 means read. A read is acknowledged but opens no write sequence. Any other device-select byte gets ack_n high.
- R3: In a write sequence, the word-address byte and every data byte that follows it are acknowledged with ack_n low.
- R4: Data byte number i (counting from 0) of a sequence that starts at word address A is written to address {A[7:4], (A[3:0]+i) mod 16}. No location outside that page changes.
- R5: When more than 16 data bytes arrive, a later byte replaces an earlier byte that has the same in-page offset. Each offset is written to the array at most once per write cycle.
- R6: A stop that follows at least one data byte raises busy on the next cycle. Busy then stays high for exactly WRITE_CYCLES cycles.
- R7: A stop that arrives before any data byte of the sequence starts no write cycle and writes nothing.
- R8: While busy is high, every received byte gets ack_n high, and start and stop events are ignored. Once busy has fallen, a new start followed by a matching device-select byte is acknowledged again.
- R9: If wp_block is high when the stop arrives, busy still lasts the full WRITE_CYCLES cycles, but mem_we stays low.
- R10: Every mem_we pulse happens while busy is high, and within one write cycle the addresses go up in ascending offset order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_sel | input | 3 | Strapped select bits that the device-select byte must match |
| wp_block | input | 1 | Protection decision, sampled at the stop that ends a write |
| ev_start | input | 1 | One-cycle pulse for a start condition |
| ev_stop | input | 1 | One-cycle pulse for a stop condition |
| ev_byte | input | 1 | One-cycle pulse marking a received byte |
| rx_byte | input | 8 | Received byte, valid with ev_byte |
| ack_vld | output | 1 | Acknowledge decision valid, one cycle after ev_byte |
| ack_n | output | 1 | Acknowledge bit to drive on the bus (0 = acknowledge) |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The checker watches several rules on every cycle. Array writes may only happen while busy is high, and a run of writes must stay within one page. Busy may only rise after a stop, and every busy window must last exactly WRITE_CYCLES cycles. A protected cycle must not write, and every byte received during busy must be refused. Other behaviours can only be shown by the bench's scenarios, because they depend on the contents of the array:

- the in-page wrap;
- the overwrite when a burst runs past sixteen bytes;
- whether a stop with no data starts a write cycle;
- whether a master that polls gets its first acknowledge exactly when the cycle ends.

The bench sweeps every start offset against burst lengths from 1 to 20 and compares the whole array after each write.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 40,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        chip_sel,
  input  logic              wp_block,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_byte,
  input  logic [7:0]        rx_byte,
  output logic              ack_vld,
  output logic              ack_n,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TMR_W = $clog2(WRITE_CYCLES) + 1;
  localparam logic [TMR_W-1:0] PAGE_T = TMR_W'(PAGE);
  localparam logic [TMR_W-1:0] LAST_T = TMR_W'(WRITE_CYCLES - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_DEV, PH_WADR, PH_DATA} phase_t;

  phase_t            phase;
  logic [ADDR_W-1:0] waddr;
  logic [PAGE-1:0]   mask;
  logic [7:0]        pbuf [PAGE];
  logic [TMR_W-1:0]  tmr;
  logic              blk;

  wire              dev_hit = rx_byte[7:4] == DEV_TYPE && rx_byte[3:1] == chip_sel;
  wire [PAGE_W-1:0] slot    = tmr[PAGE_W-1:0];

  assign mem_we    = busy && !blk && tmr < PAGE_T && mask[slot];
  assign mem_addr  = {waddr[ADDR_W-1:PAGE_W], slot};
  assign mem_wdata = pbuf[slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      waddr   <= '0;
      mask    <= '0;
      tmr     <= '0;
      blk     <= 1'b0;
      busy    <= 1'b0;
      ack_vld <= 1'b0;
      ack_n   <= 1'b1;
    end else begin
      ack_vld <= ev_byte;
      if (busy) begin
        if (ev_byte) ack_n <= 1'b1;
        tmr <= tmr + 1'b1;
        if (tmr == LAST_T) busy <= 1'b0;
      end else if (ev_start) begin
        phase <= PH_DEV;
      end else if (ev_stop) begin
        phase <= PH_IDLE;
        if (phase == PH_DATA && |mask) begin
          busy <= 1'b1;
          tmr  <= '0;
          blk  <= wp_block;
        end
      end else if (ev_byte) begin
        ack_n <= 1'b0;
        unique case (phase)
          PH_DEV: begin
            ack_n <= !dev_hit;
            phase <= (dev_hit && !rx_byte[0]) ? PH_WADR : PH_IDLE;
          end
          PH_WADR: begin
            waddr <= rx_byte[ADDR_W-1:0];
            mask  <= '0;
            phase <= PH_DATA;
          end
          PH_DATA: begin
            pbuf[waddr[PAGE_W-1:0]] <= rx_byte;
            mask[waddr[PAGE_W-1:0]] <= 1'b1;
            waddr[PAGE_W-1:0]       <= waddr[PAGE_W-1:0] + PAGE_W'(1);
          end
          default: ack_n <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_block,
  input logic              ev_stop,
  input logic              ev_byte,
  input logic              ack_vld,
  input logic              ack_n,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int CW = $clog2(WRITE_CYCLES + 1) + 1;

  logic [CW-1:0] run;
  logic          busy_q, wp_q, blk_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= '0;
      busy_q <= 1'b0;
      wp_q   <= 1'b0;
      blk_c  <= 1'b0;
    end else begin
      run    <= busy ? run + 1'b1 : '0;
      busy_q <= busy;
      wp_q   <= wp_block;
      if (busy && !busy_q) blk_c <= wp_q;
    end
  end

  wire blk_now = (busy && !busy_q) ? wp_q : blk_c;

  p_we_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ev_byte) |=> (ack_vld && ack_n));
  p_ack_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(ev_byte));
  p_busy_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_stop));
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == CW'(WRITE_CYCLES));
  p_same_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W]));
  p_no_write_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !blk_now);
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_block(wp_block), .ev_stop(ev_stop),
  .ev_byte(ev_byte), .ack_vld(ack_vld), .ack_n(ack_n), .busy(busy),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int W = 40;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 0, rst_n = 0;
  logic [2:0] chip_sel = 3'b101;
  logic wp_block = 0, ev_start = 0, ev_stop = 0, ev_byte = 0;
  logic [7:0] rx_byte = 0;
  logic ack_vld, ack_n, busy, mem_we;
  logic [7:0] mem_addr, mem_wdata;

  eeprom_page_writer #(.WRITE_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .wp_block(wp_block),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte), .rx_byte(rx_byte),
    .ack_vld(ack_vld), .ack_n(ack_n), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] mem [256];
  logic [7:0] refm [256];
  int wr_total = 0, order_err = 0, stray_err = 0, run = 0, last_run = 0;
  bit in_run = 0;
  logic [7:0] last_a = 0;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_total <= wr_total + 1;
      if (!busy) stray_err <= stray_err + 1;
      if (in_run && mem_addr <= last_a) order_err <= order_err + 1;
      last_a <= mem_addr;
      in_run <= 1;
    end
    if (busy) run <= run + 1;
    else begin
      in_run <= 0;
      if (run != 0) begin last_run <= run; run <= 0; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) ev_start = 1; @(negedge clk) ev_start = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) ev_stop = 1; @(negedge clk) ev_stop = 0;
  endtask
  task automatic send(input logic [7:0] b, input logic exp_n, input string req);
    @(negedge clk) begin ev_byte = 1; rx_byte = b; end
    @(negedge clk) ev_byte = 0;
    chk(ack_vld === 1'b1 && ack_n === exp_n, req, {ack_vld, ack_n}, {1'b1, exp_n});
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== refm[a]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic page_write(input int wa, input int n, input bit wp, input bit wait_done);
    int w0 = wr_total;
    pulse_start();
    send(DEV_W, 1'b0, "R2");
    send(8'(wa), 1'b0, "R3");
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'((wa * 37) + n * 11 + i * 5 + 1);
      send(d, 1'b0, "R3");
      if (!wp) refm[(wa & 8'hF0) | ((wa + i) & 15)] = d;
    end
    wp_block = wp;
    pulse_stop();
    wp_block = 0;
    chk(busy === 1'b1, "R6 busy after stop", busy, 1);
    if (wait_done) begin
      wait_idle();
      chk(last_run == W, "R6 busy length", last_run, W);
      if (wp) chk(wr_total == w0, "R9 no write", wr_total - w0, 0);
      else chk(wr_total - w0 == (n > 16 ? 16 : n), "R5 write count", wr_total - w0, n > 16 ? 16 : n);
      mem_cmp(wp ? "R9 array" : "R4 R5 array");
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin mem[a] = 0; refm[a] = 0; end
    repeat (3) @(negedge clk);
    chk(busy === 0 && mem_we === 0 && ack_vld === 0, "R1 reset", {busy, mem_we, ack_vld}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && ack_vld === 0, "R1 after release", {busy, ack_vld}, 0);

    pulse_start(); send(8'hA0, 1'b1, "R2 wrong chip_sel"); pulse_stop();
    pulse_start(); send(8'h6A, 1'b1, "R2 wrong type"); pulse_stop();
    pulse_start(); send(DEV_R, 1'b0, "R2 read select");
    send(8'h10, 1'b1, "R2 read opens no write"); pulse_stop();
    chk(busy === 0, "R2 read no busy", busy, 0);

    pulse_start(); send(DEV_W, 1'b0, "R2"); send(8'h33, 1'b0, "R3"); pulse_stop();
    repeat (3) @(negedge clk);
    chk(busy === 0 && wr_total == 0, "R7 stop without data", {busy, 8'(wr_total)}, 0);
    pulse_start(); send(DEV_W, 1'b0, "R2"); pulse_stop();
    repeat (3) @(negedge clk);
    chk(busy === 0 && wr_total == 0, "R7 stop after select", {busy, 8'(wr_total)}, 0);

    for (int s = 0; s < 16; s++)
      for (int n = 1; n <= 20; n++)
        page_write(((s + n) % 16) * 16 + s, n, ((s + n) % 7) == 0, 1'b1);

    page_write(8'h5E, 5, 1'b0, 1'b0);
    begin
      int polls = 0;
      bit got = 0;
      while (!got && polls < 100) begin
        bit sb;
        @(negedge clk) begin sb = busy; ev_start = 1; end
        @(negedge clk) ev_start = 0;
        send(DEV_W, sb, "R8 poll");
        polls++;
        if (sb) begin
          @(negedge clk) ev_byte = 1; @(negedge clk) ev_byte = 0;
          pulse_stop();
        end else got = 1;
      end
      chk(got && polls > 1, "R8 poll acked after cycle", polls, 2);
      chk(last_run == W, "R8 stop ignored in busy", last_run, W);
      send(8'hC7, 1'b0, "R8 continue address");
      send(8'h99, 1'b0, "R8 continue data");
      refm[8'hC7] = 8'h99;
      pulse_stop();
      wait_idle();
      mem_cmp("R8 R4 array after poll");
    end
    chk(order_err == 0, "R10 ascending order", order_err, 0);
    chk(stray_err == 0, "R10 write outside busy", stray_err, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule